// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the finite-state controller for a multi-cycle processor core. It handles a small load/store instruction subset: register-to-register arithmetic, word load, word store, branch-if-equal and unconditional jump. One memory holds both instructions and data. One ALU computes the next sequential PC, the branch target, effective addresses and arithmetic results, each in a different cycle. The holding registers between cycles are the instruction register, the A and B operand registers, the ALU result register and the memory data register. This sequencer produces their write enables, the memory strobes, the multiplexer selects and the ALU operation for every cycle.

The controller walks each instruction through only the states that instruction needs, then goes back to fetch. Branch and jump take three cycles, arithmetic and store take four, and load takes five. The decode cycle would otherwise leave the ALU idle, so the controller uses it to compute the branch target before it knows the opcode. A taken branch then needs no extra cycle. The datapath samples the opcode from the latched instruction and the ALU zero flag. It combines the control outputs with the register indices, immediate and jump field it holds itself.

Top module: `mc_ctrl_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in the fetch state, including in the middle of an instruction. The first cycle after `rst` falls shows the fetch controls.
- R2: The fetch cycle asserts `ir_we`, `mem_rd` and `pc_we`, with `addr_sel`=0 (address from PC). It also drives `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=0 (add) and `pc_src`=0 (ALU result).
- R3: The cycle after fetch is decode for every opcode. Decode asserts `a_we`, `b_we` and `aluout_we`, with `alu_a_sel`=0, `alu_b_sel`=3 (immediate shifted left by two) and `alu_op`=0.
- R4: Opcode 0x00 (arithmetic) takes 4 cycles. The third cycle drives `alu_a_sel`=1 (A), `alu_b_sel`=0 (B), `alu_op`=2 (function field) and `aluout_we`. The fourth cycle drives `rf_we` with `rf_dst_sel`=1 (rd field) and `rf_data_sel`=0 (ALU result).
- R5: Opcode 0x23 (load) takes 5 cycles. The third cycle computes the address (`alu_a_sel`=1, `alu_b_sel`=2 for the sign-extended immediate, `alu_op`=0, `aluout_we`). The fourth cycle asserts `mem_rd` and `mdr_we` with `addr_sel`=1 (address from the ALU result register). The fifth cycle asserts `rf_we` with `rf_dst_sel`=0 (rt field) and `rf_data_sel`=1 (memory data).
- R6: Opcode 0x2B (store) takes 4 cycles. The third cycle computes the address as in R5. The fourth cycle asserts `mem_wr` with `addr_sel`=1, and the register file is not written.
- R7: Opcode 0x04 (branch) takes 3 cycles. The third cycle drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1 (subtract) and `pc_src`=1 (ALU result register). In that cycle `pc_we` equals `alu_zero`.
- R8: Opcode 0x02 (jump) takes 3 cycles. The third cycle asserts `pc_we` with `pc_src`=2 (jump target from the upper PC bits, instruction bits 25:0 and two zero bits).
- R9: Any other opcode returns the controller to fetch right after decode, so it takes 2 cycles.
- R10: In every state, each control not named for that state in R2 to R8 is 0. As a result `mem_rd` and `mem_wr` are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the latched instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_we | output | 1 | PC register write |
| ir_we | output | 1 | Instruction register write |
| a_we | output | 1 | Operand A register write |
| b_we | output | 1 | Operand B register write |
| aluout_we | output | 1 | ALU result register write |
| mdr_we | output | 1 | Memory data register write |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| alu_a_sel | output | 1 | ALU input A: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU input B: 0 B, 1 four, 2 immediate, 3 immediate shifted by two |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 function field |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Write index: 0 rt, 1 rd |
| rf_data_sel | output | 1 | Write data: 0 ALU result register, 1 memory data |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU result register, 2 jump target |

## Verification
The assertions check every cycle that the memory strobes are mutually exclusive and that an instruction load is addressed from the PC. They also check that decode always follows fetch, that a load's memory-data capture is followed by its write-back, and that a branch updates the PC only when the zero flag is set. Every write-back, store or jump must be followed by fetch. The cycle count of each instruction class, the complete control vector in each state, the taken and not-taken branches, the unknown-opcode return and reset in the middle of an instruction can only be seen through the bench's directed scenarios.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_ARITH  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 6'h02;

    localparam logic [1:0] SRCB_REG   = 2'd0;
    localparam logic [1:0] SRCB_FOUR  = 2'd1;
    localparam logic [1:0] SRCB_IMM   = 2'd2;
    localparam logic [1:0] SRCB_IMMSH = 2'd3;

    localparam logic [1:0] ALU_ADD  = 2'd0;
    localparam logic [1:0] ALU_SUB  = 2'd1;
    localparam logic [1:0] ALU_FUNC = 2'd2;

    localparam logic [1:0] PCS_ALU    = 2'd0;
    localparam logic [1:0] PCS_ALUREG = 2'd1;
    localparam logic [1:0] PCS_JUMP   = 2'd2;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_LDMEM,
        ST_LDWB,
        ST_STMEM,
        ST_EXEC,
        ST_ARWB,
        ST_BRANCH,
        ST_JUMP
    } mcc_state_e;

    typedef struct packed {
        mcc_state_e state;
    } mcc_seq_t;

    typedef struct packed {
        logic       pc_we;
        logic       ir_we;
        logic       a_we;
        logic       b_we;
        logic       aluout_we;
        logic       mdr_we;
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       rf_we;
        logic       rf_dst_sel;
        logic       rf_data_sel;
        logic [1:0] pc_src;
    } mcc_ctrl_t;

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
#(
    parameter int              OP_W    = OPC_W,
    parameter logic [OP_W-1:0] OP_ARI  = OPC_ARITH,
    parameter logic [OP_W-1:0] OP_LD   = OPC_LOAD,
    parameter logic [OP_W-1:0] OP_ST   = OPC_STORE,
    parameter logic [OP_W-1:0] OP_BR   = OPC_BRANCH,
    parameter logic [OP_W-1:0] OP_JMP  = OPC_JUMP
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output mcc_state_e      state_o
);

    mcc_seq_t seq_d;
    mcc_seq_t seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_FETCH:  seq_d.state = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_ARI)
                    seq_d.state = ST_EXEC;
                else if (opcode == OP_LD || opcode == OP_ST)
                    seq_d.state = ST_ADDR;
                else if (opcode == OP_BR)
                    seq_d.state = ST_BRANCH;
                else if (opcode == OP_JMP)
                    seq_d.state = ST_JUMP;
                else
                    seq_d.state = ST_FETCH;
            end
            ST_ADDR:   seq_d.state = (opcode == OP_LD) ? ST_LDMEM : ST_STMEM;
            ST_LDMEM:  seq_d.state = ST_LDWB;
            ST_EXEC:   seq_d.state = ST_ARWB;
            default:   seq_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            seq_q.state <= ST_FETCH;
        else
            seq_q <= seq_d;
    end

    assign state_o = seq_q.state;

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  mcc_state_e state_i,
    input  logic       alu_zero,
    output mcc_ctrl_t  ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (state_i)
            ST_FETCH: begin
                ctrl_o.ir_we     = 1'b1;
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.pc_we     = 1'b1;
                ctrl_o.alu_b_sel = SRCB_FOUR;
                ctrl_o.alu_op    = ALU_ADD;
                ctrl_o.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl_o.a_we      = 1'b1;
                ctrl_o.b_we      = 1'b1;
                ctrl_o.aluout_we = 1'b1;
                ctrl_o.alu_b_sel = SRCB_IMMSH;
                ctrl_o.alu_op    = ALU_ADD;
            end
            ST_ADDR: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = SRCB_IMM;
                ctrl_o.alu_op    = ALU_ADD;
                ctrl_o.aluout_we = 1'b1;
            end
            ST_LDMEM: begin
                ctrl_o.mem_rd   = 1'b1;
                ctrl_o.addr_sel = 1'b1;
                ctrl_o.mdr_we   = 1'b1;
            end
            ST_LDWB: begin
                ctrl_o.rf_we       = 1'b1;
                ctrl_o.rf_data_sel = 1'b1;
            end
            ST_STMEM: begin
                ctrl_o.mem_wr   = 1'b1;
                ctrl_o.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = SRCB_REG;
                ctrl_o.alu_op    = ALU_FUNC;
                ctrl_o.aluout_we = 1'b1;
            end
            ST_ARWB: begin
                ctrl_o.rf_we      = 1'b1;
                ctrl_o.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = SRCB_REG;
                ctrl_o.alu_op    = ALU_SUB;
                ctrl_o.pc_src    = PCS_ALUREG;
                ctrl_o.pc_we     = alu_zero;
            end
            ST_JUMP: begin
                ctrl_o.pc_we  = 1'b1;
                ctrl_o.pc_src = PCS_JUMP;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
    import mcc_pkg::*;
#(
    parameter int OP_W = OPC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    output logic            pc_we,
    output logic            ir_we,
    output logic            a_we,
    output logic            b_we,
    output logic            aluout_we,
    output logic            mdr_we,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            addr_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op,
    output logic            rf_we,
    output logic            rf_dst_sel,
    output logic            rf_data_sel,
    output logic [1:0]      pc_src
);

    mcc_state_e state;
    mcc_ctrl_t  ctrl;

    mcc_next_state #(.OP_W(OP_W)) i_next (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .state_o (state)
    );

    mcc_out_decode i_dec (
        .state_i  (state),
        .alu_zero (alu_zero),
        .ctrl_o   (ctrl)
    );

    assign pc_we       = ctrl.pc_we;
    assign ir_we       = ctrl.ir_we;
    assign a_we        = ctrl.a_we;
    assign b_we        = ctrl.b_we;
    assign aluout_we   = ctrl.aluout_we;
    assign mdr_we      = ctrl.mdr_we;
    assign mem_rd      = ctrl.mem_rd;
    assign mem_wr      = ctrl.mem_wr;
    assign addr_sel    = ctrl.addr_sel;
    assign alu_a_sel   = ctrl.alu_a_sel;
    assign alu_b_sel   = ctrl.alu_b_sel;
    assign alu_op      = ctrl.alu_op;
    assign rf_we       = ctrl.rf_we;
    assign rf_dst_sel  = ctrl.rf_dst_sel;
    assign rf_data_sel = ctrl.rf_data_sel;
    assign pc_src      = ctrl.pc_src;

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ir_we |-> (mem_rd && !addr_sel));

    // R3
    decode_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (a_we && b_we && aluout_we));

    // R5
    load_wb_chk: assert property (@(posedge clk) disable iff (rst)
        mdr_we |=> (rf_we && rf_data_sel));

    // R4
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> ir_we);

    // R6
    store_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_we);

    // R7
    branch_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == PCS_ALUREG) |-> alu_zero);

    // R8
    jump_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == PCS_JUMP) |=> ir_we);

endmodule

// File: tb/test_mc_ctrl_seq.sv
module test_mc_ctrl_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;

    logic pc_we, ir_we, a_we, b_we, aluout_we, mdr_we, mem_rd, mem_wr;
    logic addr_sel, alu_a_sel, rf_we, rf_dst_sel, rf_data_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int K_ARI = 0, K_LD = 1, K_ST = 2, K_BR = 3, K_JMP = 4, K_BAD = 5;

    always #4 clk = ~clk;

    mc_ctrl_seq i_mc_ctrl_seq (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .pc_we(pc_we), .ir_we(ir_we), .a_we(a_we), .b_we(b_we),
        .aluout_we(aluout_we), .mdr_we(mdr_we), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .addr_sel(addr_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .rf_we(rf_we),
        .rf_dst_sel(rf_dst_sel), .rf_data_sel(rf_data_sel), .pc_src(pc_src)
    );

    function automatic logic [18:0] pack(
        input logic pcw, irw, aw, bw, aow, mdw, rd, wr, asel, sa,
        input logic [1:0] sb, op,
        input logic rfw, dst, dat,
        input logic [1:0] ps);
        return {pcw, irw, aw, bw, aow, mdw, rd, wr, asel, sa, sb, op, rfw, dst, dat, ps};
    endfunction

    function automatic logic [18:0] observed();
        return {pc_we, ir_we, a_we, b_we, aluout_we, mdr_we, mem_rd, mem_wr,
                addr_sel, alu_a_sel, alu_b_sel, alu_op, rf_we, rf_dst_sel,
                rf_data_sel, pc_src};
    endfunction

    function automatic logic [18:0] fetch_vec();
        return pack(1,1,0,0,0,0,1,0,0,0,2'd1,2'd0,0,0,0,2'd0);
    endfunction

    function automatic logic [18:0] expect_vec(input int kind, input int step, input logic z);
        if (step == 0) return fetch_vec();
        if (step == 1) return pack(0,0,1,1,1,0,0,0,0,0,2'd3,2'd0,0,0,0,2'd0);
        case (kind)
            K_ARI: return (step == 2) ? pack(0,0,0,0,1,0,0,0,0,1,2'd0,2'd2,0,0,0,2'd0)
                                      : pack(0,0,0,0,0,0,0,0,0,0,2'd0,2'd0,1,1,0,2'd0);
            K_LD, K_ST: begin
                if (step == 2) return pack(0,0,0,0,1,0,0,0,0,1,2'd2,2'd0,0,0,0,2'd0);
                if (kind == K_ST) return pack(0,0,0,0,0,0,0,1,1,0,2'd0,2'd0,0,0,0,2'd0);
                if (step == 3) return pack(0,0,0,0,0,1,1,0,1,0,2'd0,2'd0,0,0,0,2'd0);
                return pack(0,0,0,0,0,0,0,0,0,0,2'd0,2'd0,1,0,1,2'd0);
            end
            K_BR:  return pack(z,0,0,0,0,0,0,0,0,1,2'd0,2'd1,0,0,0,2'd1);
            default: return pack(1,0,0,0,0,0,0,0,0,0,2'd0,2'd0,0,0,0,2'd2);
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [18:0] exp_v);
        checks++;
        if (observed() !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, observed(), exp_v);
        end
    endtask

    task automatic run_instr(input string tag, input logic [5:0] op, input logic z,
                             input int kind, input int nsteps);
        opcode   = op;
        alu_zero = z;
        for (int s = 0; s < nsteps; s++) begin
            check_vec(s == 0 ? "R2" : (s == 1 ? "R3" : tag), expect_vec(kind, s, z));
            @(negedge clk);
        end
        check_vec({tag, " return-to-fetch"}, fetch_vec());
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_vec("R1", fetch_vec());
    endtask

    task automatic test_reset_midway();
        opcode = 6'h23;
        for (int s = 0; s < 3; s++) @(negedge clk);
        check_vec("R5", expect_vec(K_LD, 3, 1'b0));
        rst = 1'b1;
        @(negedge clk);
        check_vec("R1", fetch_vec());
        rst = 1'b0;
    endtask

    initial begin
        test_reset();
        run_instr("R4", 6'h00, 1'b0, K_ARI, 4);
        run_instr("R5", 6'h23, 1'b0, K_LD, 5);
        run_instr("R6", 6'h2B, 1'b1, K_ST, 4);
        run_instr("R7", 6'h04, 1'b1, K_BR, 3);
        run_instr("R7", 6'h04, 1'b0, K_BR, 3);
        run_instr("R8", 6'h02, 1'b0, K_JMP, 3);
        run_instr("R9", 6'h3F, 1'b0, K_BAD, 2);
        run_instr("R9", 6'h05, 1'b1, K_BAD, 2);
        run_instr("R10", 6'h23, 1'b1, K_LD, 5);
        test_reset_midway();
        run_instr("R4", 6'h00, 1'b1, K_ARI, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule